// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Victim Buffer

This block is a read-only, direct-mapped L1 data cache backed by a small fully associative victim buffer. The CPU presents a word address. The block answers from the L1 arrays when the addressed line is present. When the line is absent from L1 but held in the victim buffer, the block exchanges the two lines at a cost of one extra cycle. When the line is in neither, the block fetches the whole line from the next memory level and installs it in L1. The line that the refill pushes out of L1 then moves into the victim buffer.

The victim buffer catches lines that conflict in the same L1 set. Two or more hot lines that share an index can then be served without going to memory. Buffer entries keep the full line address, so a single entry can hold a line from any L1 set. The next-level port carries one request at a time and returns whole lines.

Top module: `victim_l1_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0, and every L1 set and buffer entry is empty, so the first access to any line goes to memory.
- R2: A request accepted while its line is in L1 gives `rsp_valid` = 1 in the next cycle, with `req_ready` still 1, and issues no memory request.
- R3: A request that misses L1 but hits the victim buffer gives `rsp_valid` one cycle later than an L1 hit, which is two cycles after acceptance, and issues no memory request. The two lines trade places: the requested line goes into L1 and the old L1 line goes into that buffer entry.
- R4: A request that misses both structures raises `mem_req_valid` for exactly one cycle, with `mem_req_line` = `req_addr >> 2`. `rsp_valid` follows one cycle after `mem_rsp_valid`, and the fetched line is installed in L1.
- R5: On a refill, a valid line displaced from L1 is written into the victim buffer. A later request to that line is served by a swap (R3 timing) without a memory request.
- R6: A displaced line goes to the lowest-numbered empty buffer entry. When all entries are valid, it overwrites the entry at a rotating pointer, which then advances, so the buffer evicts lines in first-in, first-out order.
- R7: `req_ready` is 0 while a swap or refill is in progress. At most one memory request is outstanding, so `mem_req_valid` appears once per miss and never twice without a response in between.
- R8: The address layout is word offset = `req_addr[1:0]`, L1 set = `req_addr[3:2]`, tag = `req_addr[11:4]`. On `mem_rsp_line`, word w occupies bits `[32*w +: 32]`, and `rsp_data` returns the word that the offset selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU read request |
| req_addr | input | 12 | Word address of the read |
| req_ready | output | 1 | Block can accept a request this cycle |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data word |
| mem_req_valid | output | 1 | Line fetch request to next level |
| mem_req_line | output | 10 | Line address to fetch |
| mem_rsp_valid | input | 1 | Fetched line is present |
| mem_rsp_line | input | 128 | Fetched line, four words |

## Verification
A directed phase sends repeated word offsets within one line, which separate the L1 hit path from word selection. It then sends two lines that conflict in one set and alternates between them, so the swap timing can be told apart from the refill timing. After that, a run of six conflicting lines fills the buffer and overflows it, and two follow-up requests show which entry was evicted: one line comes back by a swap and the other needs a fresh fetch, which separates first-in, first-out replacement from any other choice. A pseudo-random phase over sixteen lines mixes all three outcomes across every set. In every phase, each response's data and arrival cycle are compared with a reference model kept in the bench.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SWAP  = 2'd1,
    ST_ISSUE = 2'd2,
    ST_WAIT  = 2'd3
  } ctl_state_e;
endpackage

// File: rtl/l1_store.sv
module l1_store #(
  parameter int SETS   = 4,
  parameter int TAG_W  = 8,
  parameter int LINE_W = 128
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(SETS)-1:0] rd_idx,
  output logic                    rd_valid,
  output logic [TAG_W-1:0]        rd_tag,
  output logic [LINE_W-1:0]       rd_line,
  input  logic                    wr_en,
  input  logic [$clog2(SETS)-1:0] wr_idx,
  input  logic [TAG_W-1:0]        wr_tag,
  input  logic [LINE_W-1:0]       wr_line
);
  logic [SETS-1:0]   set_valid;
  logic [TAG_W-1:0]  set_tag  [SETS];
  logic [LINE_W-1:0] set_line [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) set_valid <= '0;
    else if (wr_en) set_valid[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      set_tag[wr_idx]  <= wr_tag;
      set_line[wr_idx] <= wr_line;
    end
  end

  assign rd_valid = set_valid[rd_idx];
  assign rd_tag   = set_tag[rd_idx];
  assign rd_line  = set_line[rd_idx];
endmodule

// File: rtl/victim_store.sv
module victim_store #(
  parameter int DEPTH  = 4,
  parameter int LA_W   = 10,
  parameter int LINE_W = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LA_W-1:0]          look_la,
  output logic                     hit,
  output logic [$clog2(DEPTH)-1:0] hit_slot,
  output logic [LINE_W-1:0]        hit_line,
  output logic [DEPTH-1:0]         match_vec,
  input  logic                     ins_en,
  input  logic [LA_W-1:0]          ins_la,
  input  logic [LINE_W-1:0]        ins_line,
  input  logic                     swap_en,
  input  logic [$clog2(DEPTH)-1:0] swap_slot,
  input  logic                     swap_valid,
  input  logic [LA_W-1:0]          swap_la,
  input  logic [LINE_W-1:0]        swap_line
);
  localparam int SW = $clog2(DEPTH);

  logic [DEPTH-1:0]  ent_valid;
  logic [LA_W-1:0]   ent_la   [DEPTH];
  logic [LINE_W-1:0] ent_line [DEPTH];
  logic [SW-1:0]     rot_ptr;
  logic [SW-1:0]     ins_slot;
  logic              all_full;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_cmp
      assign match_vec[g] = ent_valid[g] && (ent_la[g] == look_la);
    end
  endgenerate

  // lowest matching entry, lowest empty entry
  always_comb begin
    hit_slot = '0;
    ins_slot = rot_ptr;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match_vec[i])  hit_slot = SW'(i);
      if (!ent_valid[i]) ins_slot = SW'(i);
    end
  end

  function automatic logic [SW-1:0] next_ptr(input logic [SW-1:0] p);
    return (p == SW'(DEPTH - 1)) ? '0 : p + SW'(1);
  endfunction

  assign hit      = |match_vec;
  assign hit_line = ent_line[hit_slot];
  assign all_full = &ent_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid <= '0;
      rot_ptr   <= '0;
    end else if (ins_en) begin
      ent_valid[ins_slot] <= 1'b1;
      if (all_full) rot_ptr <= next_ptr(rot_ptr);
    end else if (swap_en) begin
      ent_valid[swap_slot] <= swap_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en) begin
      ent_la[ins_slot]   <= ins_la;
      ent_line[ins_slot] <= ins_line;
    end else if (swap_en) begin
      ent_la[swap_slot]   <= swap_la;
      ent_line[swap_slot] <= swap_line;
    end
  end

  // a line lives in at most one buffer entry
  assert_unique_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));
endmodule

// File: rtl/victim_l1_cache.sv
module victim_l1_cache #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int L1_SETS    = 4,
  parameter int VB_DEPTH   = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  req_valid,
  input  logic [ADDR_W-1:0]                     req_addr,
  output logic                                  req_ready,
  output logic                                  rsp_valid,
  output logic [DATA_W-1:0]                     rsp_data,
  output logic                                  mem_req_valid,
  output logic [ADDR_W-$clog2(LINE_WORDS)-1:0]  mem_req_line,
  input  logic                                  mem_rsp_valid,
  input  logic [DATA_W*LINE_WORDS-1:0]          mem_rsp_line
);
  import vlc_pkg::*;

  localparam int OFF_W  = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(L1_SETS);
  localparam int LA_W   = ADDR_W - OFF_W;
  localparam int TAG_W  = LA_W - IDX_W;
  localparam int LINE_W = DATA_W * LINE_WORDS;
  localparam int SW     = $clog2(VB_DEPTH);

  function automatic logic [LA_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction
  function automatic logic [OFF_W-1:0] off_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction
  function automatic logic [DATA_W-1:0] pick_word(input logic [LINE_W-1:0] l,
                                                  input logic [OFF_W-1:0] o);
    return l[o*DATA_W +: DATA_W];
  endfunction

  ctl_state_e          st;
  logic [ADDR_W-1:0]   cur_addr;
  logic [ADDR_W-1:0]   act_addr;
  logic [LA_W-1:0]     act_la;
  logic [IDX_W-1:0]    act_idx;
  logic [TAG_W-1:0]    act_tag;
  logic [OFF_W-1:0]    act_off;

  logic                l1_v;
  logic [TAG_W-1:0]    l1_tag;
  logic [LINE_W-1:0]   l1_line;
  logic                l1_wr;
  logic [LINE_W-1:0]   l1_wr_line;
  logic                vb_hit;
  logic [SW-1:0]       vb_slot;
  logic [LINE_W-1:0]   vb_line;
  logic [VB_DEPTH-1:0] vb_match;
  logic                l1_hit;

  // named internal events
  logic ev_accept, ev_l1_hit, ev_vb_hit, ev_miss, ev_swap, ev_fill;

  assign act_addr = (st == ST_IDLE) ? req_addr : cur_addr;
  assign act_la   = line_of(act_addr);
  assign act_idx  = act_la[IDX_W-1:0];
  assign act_tag  = act_la[LA_W-1:IDX_W];
  assign act_off  = off_of(act_addr);

  assign l1_hit    = l1_v && (l1_tag == act_tag);
  assign ev_accept = req_valid && (st == ST_IDLE);
  assign ev_l1_hit = ev_accept && l1_hit;
  assign ev_vb_hit = ev_accept && !l1_hit && vb_hit;
  assign ev_miss   = ev_accept && !l1_hit && !vb_hit;
  assign ev_swap   = (st == ST_SWAP);
  assign ev_fill   = (st == ST_WAIT) && mem_rsp_valid;

  assign l1_wr      = ev_swap || ev_fill;
  assign l1_wr_line = ev_swap ? vb_line : mem_rsp_line;

  l1_store #(.SETS(L1_SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_l1 (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(act_idx), .rd_valid(l1_v), .rd_tag(l1_tag), .rd_line(l1_line),
    .wr_en(l1_wr), .wr_idx(act_idx), .wr_tag(act_tag), .wr_line(l1_wr_line)
  );

  victim_store #(.DEPTH(VB_DEPTH), .LA_W(LA_W), .LINE_W(LINE_W)) u_vb (
    .clk(clk), .rst_n(rst_n),
    .look_la(act_la), .hit(vb_hit), .hit_slot(vb_slot), .hit_line(vb_line),
    .match_vec(vb_match),
    .ins_en(ev_fill && l1_v), .ins_la({l1_tag, act_idx}), .ins_line(l1_line),
    .swap_en(ev_swap), .swap_slot(vb_slot), .swap_valid(l1_v),
    .swap_la({l1_tag, act_idx}), .swap_line(l1_line)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cur_addr  <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        ST_IDLE: if (ev_accept) begin
          cur_addr <= req_addr;
          if (l1_hit) begin
            rsp_valid <= 1'b1;
            rsp_data  <= pick_word(l1_line, act_off);
          end else if (vb_hit) st <= ST_SWAP;
          else                 st <= ST_ISSUE;
        end
        ST_SWAP: begin
          rsp_valid <= 1'b1;
          rsp_data  <= pick_word(vb_line, act_off);
          st        <= ST_IDLE;
        end
        ST_ISSUE: st <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          rsp_valid <= 1'b1;
          rsp_data  <= pick_word(mem_rsp_line, act_off);
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == ST_IDLE);
  assign mem_req_valid = (st == ST_ISSUE);
  assign mem_req_line  = act_la;

  assert_hit_next_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_l1_hit |=> rsp_valid && req_ready && !mem_req_valid);
  assert_swap_extra_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vb_hit |=> (!rsp_valid && !req_ready && !mem_req_valid) ##1 rsp_valid);
  assert_miss_requests_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> mem_req_valid && !req_ready);
  assert_fill_responds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill |=> rsp_valid && req_ready);
  assert_single_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);
  assert_l1_vb_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !(l1_hit && vb_hit));
endmodule

// File: tb/victim_l1_cache_bench.sv
module victim_l1_cache_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_LAT    = 3;
  localparam int SETS       = 4;
  localparam int VBD        = 4;
  localparam int WDOG       = 100000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [11:0]  req_addr = '0;
  logic         req_ready;
  logic         rsp_valid;
  logic [31:0]  rsp_data;
  logic         mem_req_valid;
  logic [9:0]   mem_req_line;
  logic         mem_rsp_valid = 1'b0;
  logic [127:0] mem_rsp_line = '0;

  victim_l1_cache u_victim_l1_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_line(mem_req_line),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_line(mem_rsp_line)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0;
  int n_fail   = 0;
  int fill_cyc = 0;
  int n_mem_req = 0;
  int n_miss_exp = 0;

  typedef struct {
    logic [31:0] data;
    int          kind;   // 0 hit, 1 swap, 2 miss
    int          acc;
    string       tag;
  } sb_item_t;
  sb_item_t   sb_q[$];
  logic [9:0] mem_q[$];

  // reference state
  logic       m_l1v [SETS];
  logic [9:0] m_l1la[SETS];
  logic       m_vbv [VBD];
  logic [9:0] m_vbla[VBD];
  int         m_ptr;

  function automatic logic [31:0] mem_word(input logic [9:0] la, input int w);
    return ({22'd0, la} * 32'h9E37_79B1) ^ (w * 32'h0101_0101) ^ 32'h5A00_0000;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int predict(input logic [9:0] la);
    int s;
    int j;
    logic [9:0] old;
    s = int'(la[1:0]);
    if (m_l1v[s] && m_l1la[s] == la) return 0;
    for (int i = 0; i < VBD; i++) begin
      if (m_vbv[i] && m_vbla[i] == la) begin
        m_vbla[i] = m_l1la[s];
        m_vbv[i]  = m_l1v[s];
        m_l1la[s] = la;
        m_l1v[s]  = 1'b1;
        return 1;
      end
    end
    old = m_l1la[s];
    if (m_l1v[s]) begin
      j = -1;
      for (int i = VBD - 1; i >= 0; i--) if (!m_vbv[i]) j = i;
      if (j < 0) begin
        j = m_ptr;
        m_ptr = (m_ptr + 1) % VBD;
      end
      m_vbv[j]  = 1'b1;
      m_vbla[j] = old;
    end
    m_l1la[s] = la;
    m_l1v[s]  = 1'b1;
    return 2;
  endfunction

  // driver: called at a falling edge
  task automatic do_req(input logic [11:0] a, input string tag);
    sb_item_t it;
    while (!req_ready) @(negedge clk);
    it.kind = predict(a[11:2]);
    it.data = mem_word(a[11:2], int'(a[1:0]));
    it.acc  = cyc + 1;
    it.tag  = tag;
    sb_q.push_back(it);
    if (it.kind == 2) begin
      mem_q.push_back(a[11:2]);
      n_miss_exp++;
    end
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (it.kind == 0) check(req_ready == 1'b1, "R2", "ready after hit", {31'd0, req_ready}, 32'd1);
    else check(req_ready == 1'b0, "R7", "ready while busy", {31'd0, req_ready}, 32'd0);
  endtask

  // monitor: pops expected items as responses appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R2", "unexpected response", rsp_data, 32'd0);
      end else begin
        sb_item_t it;
        int exp_cyc;
        it = sb_q.pop_front();
        check(rsp_data == it.data, it.tag, "data (R8 word select)", rsp_data, it.data);
        exp_cyc = (it.kind == 0) ? it.acc : (it.kind == 1) ? it.acc + 1 : fill_cyc;
        check(cyc == exp_cyc, it.tag, "response cycle", cyc, exp_cyc);
      end
    end
  end

  // next-level memory model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid) begin
        logic [9:0] la;
        n_mem_req++;
        if (mem_q.size() == 0) begin
          check(1'b0, "R3", "memory request on hit or swap", {22'd0, mem_req_line}, 32'd0);
          la = mem_req_line;
        end else begin
          la = mem_q.pop_front();
          check(mem_req_line == la, "R4", "line address", {22'd0, mem_req_line}, {22'd0, la});
        end
        repeat (MEM_LAT - 1) @(negedge clk);
        for (int w = 0; w < 4; w++) mem_rsp_line[w*32 +: 32] = mem_word(la, w);
        mem_rsp_valid = 1'b1;
        fill_cyc = cyc + 1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        if (mem_req_valid) check(1'b0, "R7", "second request pending", 32'd1, 32'd0);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < SETS; i++) begin m_l1v[i] = 1'b0; m_l1la[i] = '0; end
    for (int i = 0; i < VBD; i++)  begin m_vbv[i] = 1'b0;  m_vbla[i] = '0; end
    m_ptr = 0;
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
    check(mem_req_valid == 1'b0, "R1", "mem_req_valid in reset", {31'd0, mem_req_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready after reset", {31'd0, req_ready}, 32'd1);

    // line L word w -> address L*4+w; lines 0,4,8,... share set 0
    do_req(12'd1,       "R1");       // cold miss
    do_req(12'd3,       "R2");       // hit, other word
    do_req(12'd0,       "R8");       // hit, word 0
    do_req(12'd16 + 0,  "R4");       // line 4 miss, line 0 to buffer
    do_req(12'd2,       "R5");       // line 0 swap back
    do_req(12'd16 + 1,  "R3");       // line 4 swap
    do_req(12'd16 + 2,  "R2");       // hit after swap
    do_req(12'd32,      "R4");       // line 8
    do_req(12'd48,      "R4");       // line 12
    do_req(12'd64,      "R4");       // line 16, buffer now full
    do_req(12'd80,      "R6");       // line 20 evicts oldest (line 0)
    do_req(12'd3,       "R6");       // line 0 must refetch
    do_req(12'd32 + 3,  "R6");       // line 8 still buffered: swap
    do_req(12'd16 + 3,  "R6");       // line 4 evicted second: refetch
    do_req(12'd5,       "R4");       // other set
    do_req(12'd21,      "R5");       // set 1 conflict
    do_req(12'd6,       "R3");       // swap in set 1

    lfsr = 16'hACE1;
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      do_req({6'd0, lfsr[5:0]}, "R6");
    end

    repeat (MEM_LAT + 6) @(negedge clk);
    check(sb_q.size() == 0, "R2", "responses outstanding", sb_q.size(), 32'd0);
    check(n_mem_req == n_miss_exp, "R7", "memory request count", n_mem_req, n_miss_exp);
    finish_run();
  end
endmodule